// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital controller of a 16-bit successive-approximation converter. One master clock drives it. After reset it first runs a long timed self-calibration interval, during which no sample can be taken. It then repeats a frame with three parts. First the input is tracked with a coarse charge and then a fine charge. Next the sample is converted bit by bit against an external comparator. Finally the finished code is published with a one-clock strobe. The analog DAC and the comparator sit outside the block: it drives the DAC trial word and reads back a single comparator decision.

There are two operating modes. In free-run mode the frame has a fixed length of 80 master clocks: 6 coarse, 9 fine, 1 settle and 64 bit-trial clocks. This gives a 20 kHz sample rate from a 1.6 MHz clock. In triggered mode the fine charge lasts until an external hold request is captured on a falling clock edge, and the conversion starts on the rising edge after that. A channel-select input picks which of two inputs the next acquisition tracks.

The controller is a four-state machine. CAL is the calibration wait. COARSE is the coarse charge. FINE is the fine charge. CONV is the settle clock plus the bit trials. The transitions are: CAL to COARSE when the calibration count expires; COARSE to FINE after the coarse count; FINE to CONV after the fine count in free-run mode, or on a captured hold in triggered mode; CONV to COARSE after the last bit decision. Reset sends every state to CAL.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset is released, `ready` stays low for CAL_CLKS rising clock edges. It rises in the cycle after the CAL_CLKS-th edge and stays high until the next reset. No acquisition or conversion happens while it is low.
- R2: Every acquisition starts with COARSE_CLKS (6) cycles in which `coarse` is 1 and a `trk` bit is set. It then continues with fine charge, where `coarse` is 0 and the `trk` bit is still set.
- R3: With `trig_mode`=0, the fine charge lasts FINE_CLKS (9) cycles and the conversion lasts 65 cycles. Frames repeat every 80 cycles with no gap.
- R4: With `trig_mode`=1, `hold_req` is sampled on the falling clock edge, and only during fine charge. A high sample starts the conversion on the next rising edge, so `result_valid` appears 66 cycles after the cycle in which `hold_req` was high. Without a hold, acquisition continues indefinitely.
- R5: A `hold_req` that is high during calibration, coarse charge or conversion is ignored. It starts no conversion and does not disturb the conversion in progress.
- R6: Conversion is MSB first. One settle cycle with `dac_word`=0 comes first. Then each bit gets BIT_CLKS (4) cycles in which `dac_word` equals the bits already kept OR'ed with the trial bit. The trial bit is kept when `cmp_keep`=1 in the last cycle of its slot. `cmp_keep`=1 means the DAC level is at or below the input. `dac_word` is 0 outside the bit-trial cycles.
- R7: If `cmp_keep` is 1 for every trial (input above the top of the range), the result is 16'hFFFF. If it is 0 for every trial (input below the bottom of the range), the result is 16'h0000.
- R8: `result_valid` is a one-cycle pulse in the cycle after the last bit decision. `result` takes the new code in that same cycle and holds it until the next pulse.
- R9: The value of `ch_sel` at the rising edge that starts an acquisition sets `trk`: 2'b01 for channel 0 and 2'b10 for channel 1. The setting holds for the whole acquisition, and `trk` is 2'b00 outside acquisition.
- R10: While `rst_n` is low, `ready`, `coarse`, `trk`, `dac_word`, `result` and `result_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_mode | input | 1 | 0 = free-run frames, 1 = conversions started by hold |
| hold_req | input | 1 | Start-of-conversion request, sampled on the falling clock edge |
| ch_sel | input | 1 | Channel to track in the next acquisition |
| cmp_keep | input | 1 | Comparator decision: 1 when the DAC level is at or below the input |
| ready | output | 1 | Low during calibration, high once sampling is possible |
| trk | output | 2 | One-hot tracking indicator per channel |
| coarse | output | 1 | High during the coarse-charge part of acquisition |
| dac_word | output | 16 | Trial word for the external DAC |
| result | output | 16 | Last finished conversion code |
| result_valid | output | 1 | One-cycle strobe when `result` is updated |

## Verification
The assertions assume that `trig_mode` stays constant between resets, that `hold_req` changes only away from the falling edge, and that `cmp_keep` is a settled function of `dac_word` by the end of each bit slot. The bench changes its inputs a few nanoseconds after the rising edge and changes the mode only while reset is asserted. It models the comparator as an ideal comparison of `dac_word` with an integer input level. That level may lie outside the 16-bit range, which exercises saturation. It is changed only at frame boundaries when a specific code is expected.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        ST_CAL    = 2'd0,
        ST_COARSE = 2'd1,
        ST_FINE   = 2'd2,
        ST_CONV   = 2'd3
    } seq_state_t;

    localparam int N_CH = 2;

endpackage

// File: rtl/sar_cal_timer.sv
module sar_cal_timer #(
    parameter int CAL_CLKS = 2882040
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int W = $clog2(CAL_CLKS + 1);

    logic [W-1:0] cnt_q;

    assign expire = run && (cnt_q == W'(CAL_CLKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run && !expire) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R1: once expired the timer must not be running again before reset
    a_r1_expire_once: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !run);

endmodule

// File: rtl/sar_hold_capture.sv
module sar_hold_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic hold_req,
    output logic seen
);
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen <= 1'b0;
        end else begin
            seen <= arm & hold_req;
        end
    end

    // R5: a request arriving while not armed is never remembered
    a_r5_unarmed_drop: assert property (@(negedge clk) disable iff (!rst_n)
        !arm |=> !seen);

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
    parameter int RES_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                decide,
    input  logic                keep,
    output logic [RES_BITS-1:0] trial,
    output logic [RES_BITS-1:0] code
);
    logic [RES_BITS-1:0] acc_q;
    logic [RES_BITS-1:0] mask_q;
    logic [RES_BITS-1:0] code_q;

    assign trial = acc_q | mask_q;
    assign code  = code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            mask_q <= '0;
            code_q <= '0;
        end else if (start) begin
            acc_q  <= '0;
            mask_q <= {1'b1, {(RES_BITS-1){1'b0}}};
        end else if (decide) begin
            if (keep) begin
                acc_q <= acc_q | mask_q;
            end
            mask_q <= mask_q >> 1;
            if (mask_q[0]) begin
                code_q <= keep ? (acc_q | mask_q) : acc_q;
            end
        end
    end

    // R6: a decision never clears a bit that was already kept
    a_r6_kept_bits_stay: assert property (@(posedge clk) disable iff (!rst_n)
        decide |=> ((acc_q & $past(acc_q)) == $past(acc_q)));

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
    parameter int RES_BITS    = 16,
    parameter int CAL_CLKS    = 2882040,
    parameter int COARSE_CLKS = 6,
    parameter int FINE_CLKS   = 9,
    parameter int BIT_CLKS    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trig_mode,
    input  logic                hold_req,
    input  logic                ch_sel,
    input  logic                cmp_keep,
    output logic                ready,
    output logic [1:0]          trk,
    output logic                coarse,
    output logic [RES_BITS-1:0] dac_word,
    output logic [RES_BITS-1:0] result,
    output logic                result_valid
);
    import sar_seq_pkg::*;

    localparam int CONV_CLKS = 1 + RES_BITS * BIT_CLKS;
    localparam int LONG_A    = (COARSE_CLKS > FINE_CLKS) ? COARSE_CLKS : FINE_CLKS;
    localparam int LONGEST   = (LONG_A > CONV_CLKS) ? LONG_A : CONV_CLKS;
    localparam int CNT_W     = $clog2(LONGEST + 1);
    localparam int SLOT_W    = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;

    seq_state_t          st_q, st_d;
    logic [CNT_W-1:0]    cnt_q;
    logic [SLOT_W-1:0]   slot_q;
    logic                chan_q;
    logic                valid_q;
    logic                cal_expire;
    logic                hold_seen;
    logic                conv_start;
    logic                bit_decide;
    logic                bit_last;
    logic                acquiring;
    logic                dac_en;
    logic [RES_BITS-1:0] trial_word;
    logic [RES_BITS-1:0] code_word;

    sar_cal_timer #(
        .CAL_CLKS(CAL_CLKS)
    ) u_cal (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (st_q == ST_CAL),
        .expire (cal_expire)
    );

    sar_hold_capture u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (trig_mode && (st_q == ST_FINE)),
        .hold_req (hold_req),
        .seen     (hold_seen)
    );

    assign conv_start = (st_q == ST_CONV) && (cnt_q == '0);
    assign bit_decide = (st_q == ST_CONV) && (cnt_q != '0)
                        && (slot_q == SLOT_W'(BIT_CLKS - 1));
    assign bit_last   = (st_q == ST_CONV) && (cnt_q == CNT_W'(CONV_CLKS - 1));

    sar_bit_engine #(
        .RES_BITS(RES_BITS)
    ) u_bits (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (conv_start),
        .decide (bit_decide),
        .keep   (cmp_keep),
        .trial  (trial_word),
        .code   (code_word)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_CAL: begin
                if (cal_expire) st_d = ST_COARSE;
            end
            ST_COARSE: begin
                if (cnt_q == CNT_W'(COARSE_CLKS - 1)) st_d = ST_FINE;
            end
            ST_FINE: begin
                if (trig_mode ? hold_seen : (cnt_q == CNT_W'(FINE_CLKS - 1)))
                    st_d = ST_CONV;
            end
            ST_CONV: begin
                if (cnt_q == CNT_W'(CONV_CLKS - 1)) st_d = ST_COARSE;
            end
            default: st_d = ST_CAL;
        endcase
    end

    // state register and phase counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_CAL;
            cnt_q   <= '0;
            slot_q  <= '0;
            chan_q  <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            valid_q <= bit_last;
            if (st_d != st_q) begin
                cnt_q <= '0;
            end else if (cnt_q != '1) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if ((st_q == ST_CONV) && (cnt_q != '0)) begin
                slot_q <= (slot_q == SLOT_W'(BIT_CLKS - 1)) ? '0 : slot_q + 1'b1;
            end else begin
                slot_q <= '0;
            end
            if ((st_d == ST_COARSE) && (st_q != ST_COARSE)) begin
                chan_q <= ch_sel;
            end
        end
    end

    // outputs
    always_comb begin
        ready     = 1'b1;
        coarse    = 1'b0;
        acquiring = 1'b0;
        dac_en    = 1'b0;
        unique case (st_q)
            ST_CAL:    ready = 1'b0;
            ST_COARSE: begin
                coarse    = 1'b1;
                acquiring = 1'b1;
            end
            ST_FINE:   acquiring = 1'b1;
            ST_CONV:   dac_en = (cnt_q != '0);
            default:   ready = 1'b0;
        endcase
        dac_word = dac_en ? trial_word : '0;
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_trk
        assign trk[g] = acquiring && (chan_q == 1'(g));
    end

    assign result       = code_word;
    assign result_valid = valid_q;

    // R1: sampling, once enabled, stays enabled
    a_r1_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R8: the strobe lasts exactly one cycle
    a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    // R8: the published code only changes together with the strobe
    a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> $stable(result));

    // R9: the tracked channel does not switch within one acquisition
    a_r9_trk_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (|trk) |=> ((trk == 2'b00) || $stable(trk)));

    // R4: a conversion is always entered from fine charge
    a_r4_conv_from_fine: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> ($past(st_q) == ST_FINE));

endmodule

// File: tb/sim_sar_conv_seq.sv
`timescale 1ns/1ps
module sim_sar_conv_seq;

    localparam int BITS   = 16;
    localparam int CAL    = 300;
    localparam int COARSE = 6;
    localparam int FINE   = 9;
    localparam int BCLK   = 4;
    localparam int CONVN  = 1 + BITS * BCLK;

    logic            clk;
    logic            rst_n;
    logic            trig_mode;
    logic            hold_req;
    logic            ch_sel;
    logic            cmp_keep;
    logic            ready;
    logic [1:0]      trk;
    logic            coarse;
    logic [BITS-1:0] dac_word;
    logic [BITS-1:0] result;
    logic            result_valid;

    int vin;
    int n_chk;
    int n_fail;
    bit done;

    // reference model state
    int cal_n;
    int t_acq;
    int t_conv;
    int m_acc;
    int m_res;
    bit m_chan;
    bit m_valid;

    assign cmp_keep = (int'(dac_word) <= vin);

    sar_conv_seq #(
        .RES_BITS(BITS), .CAL_CLKS(CAL), .COARSE_CLKS(COARSE),
        .FINE_CLKS(FINE), .BIT_CLKS(BCLK)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .trig_mode(trig_mode), .hold_req(hold_req),
        .ch_sel(ch_sel), .cmp_keep(cmp_keep), .ready(ready), .trk(trk),
        .coarse(coarse), .dac_word(dac_word), .result(result),
        .result_valid(result_valid)
    );

    initial begin
        clk = 1'b0;
        forever #10 clk = ~clk;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h) t=%0t",
                     tag, act, act, exp, exp, $time);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        end
    endtask

    // cycle-by-cycle reference comparison, sampled 5 ns after the rising edge
    always @(posedge clk) begin
        int trial;
        int e_dac;
        int e_trk;
        bit nv;
        #5;
        if (!rst_n) begin
            cal_n = 0; t_acq = -1; t_conv = -1;
            m_acc = 0; m_res = 0; m_chan = 1'b0; m_valid = 1'b0;
        end
        e_dac = (t_conv >= 1) ? (m_acc | (1 << (BITS - 1 - (t_conv - 1) / BCLK))) : 0;
        e_trk = (t_acq >= 0) ? (m_chan ? 2 : 1) : 0;
        check(ready == (rst_n && cal_n >= CAL), "R1 ready", ready, int'(rst_n && cal_n >= CAL));
        check(coarse == (t_acq >= 0 && t_acq < COARSE), "R2 coarse", coarse,
              int'(t_acq >= 0 && t_acq < COARSE));
        check(int'(trk) == e_trk, "R9 trk", trk, e_trk);
        check(int'(dac_word) == e_dac, "R6 dac_word", dac_word, e_dac);
        check(result_valid == m_valid, "R8 result_valid", result_valid, m_valid);
        check(int'(result) == m_res, "R8 result", result, m_res);
        if (rst_n) begin
            nv = 1'b0;
            if (cal_n < CAL) begin
                cal_n++;
                if (cal_n == CAL) begin t_acq = 0; m_chan = ch_sel; end
            end else if (t_acq >= 0) begin
                if (t_acq >= COARSE &&
                    (trig_mode ? hold_req : (t_acq == COARSE + FINE - 1))) begin
                    t_acq = -1; t_conv = 0; m_acc = 0;
                end else begin
                    t_acq++;
                end
            end else if (t_conv >= 0) begin
                if (t_conv >= 1 && (t_conv - 1) % BCLK == BCLK - 1) begin
                    trial = m_acc | (1 << (BITS - 1 - (t_conv - 1) / BCLK));
                    if (trial <= vin) m_acc = trial;
                end
                if (t_conv == CONVN - 1) begin
                    m_res = m_acc; nv = 1'b1; t_conv = -1; t_acq = 0; m_chan = ch_sel;
                end else begin
                    t_conv++;
                end
            end
            m_valid = nv;
        end
    end

    task automatic cyc(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic wait_valid(input int limit, output int waited);
        waited = 0;
        cyc(1);
        waited = 1;
        while (!result_valid && waited < limit) begin
            cyc(1);
            waited++;
        end
    endtask

    task automatic count_valid(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            if (result_valid) cnt++;
            cyc(1);
        end
    endtask

    initial begin
        int n;
        int w;
        n_chk = 0; n_fail = 0; done = 1'b0;
        rst_n = 1'b0; trig_mode = 1'b0; hold_req = 1'b0; ch_sel = 1'b0;
        vin = 16'h1234;
        cyc(3);
        // R10: reset values
        check({ready, coarse, trk, result_valid} == 5'b0, "R10 control outputs in reset",
              {ready, coarse, trk, result_valid}, 0);
        check(dac_word == '0 && result == '0, "R10 data outputs in reset", result, 0);

        // R1: calibration length
        rst_n = 1'b1;
        n = 0;
        while (!ready && n < CAL + 10) begin cyc(1); n++; end
        check(n == CAL, "R1 cycles before ready", n, CAL);

        // R3: free-run frame rate (samples from the first ready cycle)
        count_valid(800, n);
        check(n == 9, "R3 strobes in 800 free-run cycles", n, 9);
        check(result == 16'h1234, "R6 code for 0x1234", result, 16'h1234);

        // R6 / R9: new level and channel 1, applied at a frame boundary
        wait_valid(200, w);
        vin = 16'hBEEF; ch_sel = 1'b1;
        wait_valid(200, w);
        check(w == 80, "R3 frame spacing", w, 80);
        check(result == 16'hBEEF, "R6 code for 0xBEEF", result, 16'hBEEF);
        check(trk == 2'b10, "R9 channel 1 tracked", trk, 2);
        ch_sel = 1'b0;
        wait_valid(200, w);
        check(trk == 2'b01, "R9 channel 0 tracked", trk, 1);

        // R7: saturation both ways
        vin = 70000;
        wait_valid(200, w);
        wait_valid(200, w);
        check(result == 16'hFFFF, "R7 over-range saturates high", result, 16'hFFFF);
        vin = -5;
        wait_valid(200, w);
        wait_valid(200, w);
        check(result == 16'h0000, "R7 under-range saturates low", result, 0);

        // triggered mode; hold held high through most of calibration (R5)
        rst_n = 1'b0; trig_mode = 1'b1; hold_req = 1'b1; vin = 16'h00A5;
        cyc(2);
        rst_n = 1'b1;
        cyc(CAL - 20);
        hold_req = 1'b0;
        n = 0;
        while (!ready && n < 100) begin cyc(1); n++; end
        check(ready == 1'b1, "R1 ready in triggered mode", ready, 1);
        count_valid(300, n);
        check(n == 0, "R5 R4 no conversion without fine-charge hold", n, 0);

        // R4: hold pulse in fine charge
        hold_req = 1'b1;
        cyc(1);
        hold_req = 1'b0;
        wait_valid(200, w);
        check(w == 65, "R4 strobe 66 cycles after hold", w + 1, 66);
        check(result == 16'h00A5, "R4 triggered code", result, 16'h00A5);

        // R5: hold during coarse charge is ignored
        hold_req = 1'b1;
        cyc(6);
        hold_req = 1'b0;
        count_valid(150, n);
        check(n == 0, "R5 hold in coarse ignored", n, 0);

        // R5: hold during conversion is ignored
        vin = 16'h7001;
        hold_req = 1'b1;
        cyc(1);
        hold_req = 1'b0;
        cyc(20);
        hold_req = 1'b1;
        cyc(1);
        hold_req = 1'b0;
        count_valid(200, n);
        check(n == 1, "R5 hold in conversion ignored", n, 1);
        check(result == 16'h7001, "R5 conversion undisturbed", result, 16'h7001);

        cyc(5);
        summary();
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

endmodule